// File: doc/BRIEF.md
# Keyed-Register Watchdog Timer

This block is a memory-mapped watchdog with a 16-bit register interface. A write changes the timer's state only when it carries the exact key value for that action, so a stray store cannot start, stop or feed the counter. Stopping the timer takes two keyed writes to two separate registers, in sequence. A slow time base drives the countdown: one decrement per `tickEn` pulse, one pulse per 10 ms in normal use.

Software programs a 15-bit timeout and then feeds the dog with a key. One tick before the counter would expire, an early-warning event is latched, and it reaches the interrupt pin when the mask allows it. When the count expires, the block pulses a reset request for one cycle, latches a sticky timed-out status, reloads the count and keeps running. A debug input holds the counter unless software has set an override bit. Reads are combinational from the offset on `addr`, and a flag in the count readback marks a value that is changing in that cycle.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the timer is disabled (offset 0x0C reads 0xDABE), the timeout reads 6000, status (0x10), count (0x14), event (0x20), mask (0x24) and debug-enable bit are all 0, `irqOut` and `resetReq` are low, and any undefined offset such as 0x2C reads 0.
- R2: Writing 0xFEED to offset 0x00 loads the count from the timeout and enables the timer. Any other value written there changes nothing.
- R3: A write to offset 0x04 stores bits [14:0] as the timeout and drops bit 15. Reading 0x04 returns the stored value.
- R4: While the timer is running, each cycle with `tickEn` high decrements the count. Offset 0x14 returns the count in bits [14:0]. Bit 15 reads 1 in exactly those cycles where `tickEn` is high and the timer is running.
- R5: A tick taken at count 0 drives `resetReq` high for the following cycle only. The same tick reloads the count from the timeout, and counting continues.
- R6: After an expiry, offset 0x10 reads 0xCFE8 until 0xE8B4 is written there. Any other value written to 0x10 leaves it unchanged.
- R7: 0x2BAD written to 0x08 arms the disable sequence. A following 0xCAFE written to 0x0C disables the timer. Any write to 0x0C, or any other value written to 0x08, clears the arm, so 0xCAFE without the arm does nothing. Offset 0x0C reads 0x0000 while the timer is enabled. While disabled, ticks leave the count unchanged.
- R8: Writing 0xACED to offset 0x1C re-enables a disabled timer and keeps its count. Any other value written there does nothing.
- R9: Event bit 0 at offset 0x20 is set by the tick that takes the count from 1 to 0, and is cleared by writing 1 to that bit. Writing 1 to bit 0 of 0x28 sets the event. Offset 0x28 reads 0.
- R10: `irqOut` equals the event bit ANDed with mask bit 0 at offset 0x24.
- R11: Offset 0x18 returns the `dbgMode` input in bit 1 and a writable override in bit 0. While `dbgMode` is high and the override is 0, ticks leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | 6 | Byte offset for reads and writes |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data for `addr` |
| tickEn | input | 1 | Time-base pulse, one per count unit |
| dbgMode | input | 1 | Debugger attached |
| irqOut | output | 1 | Early-warning interrupt |
| resetReq | output | 1 | One-cycle reset request at expiry |

## Verification
The assertions check on every cycle that:
- `resetReq` never lasts more than one cycle.
- `resetReq` always appears with the status latched and the count reloaded from the previous timeout.
- The count never moves while the timer is disabled or held by the debugger.
- The tick from 1 to 0 always leaves the event set.

Only the bench's scenarios can show the rest:
- Wrong keys are truly ignored.
- The two-register disable needs its order, and the arm is lost on any other write.
- Resume keeps the count.
- The unstable flag appears during ticks.
- The full countdown behaves as stated across a sweep of small timeouts.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam int ADDR_W = 6;

  // register offsets
  localparam logic [ADDR_W-1:0] OFF_FEED    = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_TIMEOUT = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_HALT1   = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_HALT2   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_STATUS  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_COUNT   = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_DEBUG   = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_RESUME  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_EVENT   = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_MASK    = 6'h24;
  localparam logic [ADDR_W-1:0] OFF_FORCE   = 6'h28;

  // write keys and readback codes
  localparam logic [15:0] KEY_FEED     = 16'hFEED;
  localparam logic [15:0] KEY_HALT1    = 16'h2BAD;
  localparam logic [15:0] KEY_HALT2    = 16'hCAFE;
  localparam logic [15:0] KEY_RESUME   = 16'hACED;
  localparam logic [15:0] KEY_CLEAR    = 16'hE8B4;
  localparam logic [15:0] CODE_HALTED  = 16'hDABE;
  localparam logic [15:0] CODE_TRIPPED = 16'hCFE8;

  typedef struct packed {
    logic        feed;
    logic        resume;
    logic        halt;
    logic        loadTimeout;
    logic        ackEvt;
    logic        forceEvt;
    logic        clearStatus;
    logic        loadMask;
    logic        loadDbg;
    logic [15:0] data;
  } wdogStrobe_t;
endpackage

// File: rtl/keyed_wdog_ctrl.sv
module keyed_wdog_ctrl
  import keyed_wdog_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  input  logic [CNT_W-1:0]  countQ,
  input  logic [CNT_W-1:0]  timeoutQ,
  input  logic              enabledQ,
  input  logic              timedOutQ,
  input  logic              evtQ,
  input  logic              maskQ,
  input  logic              dbgEnQ,
  input  logic              dbgMode,
  input  logic              countBusy,
  output wdogStrobe_t       stb,
  output logic [15:0]       rdData
);
  logic armedQ;

  function automatic logic hit(input logic [ADDR_W-1:0] off, input logic [15:0] key);
    return wrEn && addr == off && wrData == key;
  endfunction

  always_comb begin
    stb             = '0;
    stb.data        = wrData;
    stb.feed        = hit(OFF_FEED, KEY_FEED);
    stb.resume      = hit(OFF_RESUME, KEY_RESUME);
    stb.halt        = armedQ && hit(OFF_HALT2, KEY_HALT2);
    stb.clearStatus = hit(OFF_STATUS, KEY_CLEAR);
    stb.loadTimeout = wrEn && addr == OFF_TIMEOUT;
    stb.ackEvt      = wrEn && addr == OFF_EVENT && wrData[0];
    stb.forceEvt    = wrEn && addr == OFF_FORCE && wrData[0];
    stb.loadMask    = wrEn && addr == OFF_MASK;
    stb.loadDbg     = wrEn && addr == OFF_DEBUG;
  end

  // first half of the disable sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armedQ <= 1'b0;
    else if (wrEn && addr == OFF_HALT1) armedQ <= (wrData == KEY_HALT1);
    else if (wrEn && addr == OFF_HALT2) armedQ <= 1'b0;
  end

  always_comb begin
    case (addr)
      OFF_TIMEOUT: rdData = 16'(timeoutQ);
      OFF_HALT2:   rdData = enabledQ ? 16'h0000 : CODE_HALTED;
      OFF_STATUS:  rdData = timedOutQ ? CODE_TRIPPED : 16'h0000;
      OFF_COUNT:   rdData = {countBusy, 15'(countQ)};
      OFF_DEBUG:   rdData = {14'b0, dbgMode, dbgEnQ};
      OFF_EVENT:   rdData = {15'b0, evtQ};
      OFF_MASK:    rdData = {15'b0, maskQ};
      default:     rdData = 16'h0000;
    endcase
  end
endmodule

// File: rtl/keyed_wdog_dp.sv
module keyed_wdog_dp
  import keyed_wdog_pkg::*;
#(
  parameter int CNT_W       = 15,
  parameter int DEF_TIMEOUT = 6000
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdogStrobe_t      stb,
  input  logic             tickEn,
  input  logic             dbgMode,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] timeoutQ,
  output logic             enabledQ,
  output logic             timedOutQ,
  output logic             evtQ,
  output logic             maskQ,
  output logic             dbgEnQ,
  output logic             countBusy,
  output logic             resetReq,
  output logic             irqOut
);
  localparam logic [CNT_W-1:0] TIMEOUT_RST = CNT_W'(DEF_TIMEOUT);
  localparam logic [CNT_W-1:0] ONE         = CNT_W'(1);

  logic running, step, expire, warn;

  assign running   = enabledQ && (!dbgMode || dbgEnQ);
  assign step      = tickEn && running;
  assign expire    = step && countQ == '0;
  assign warn      = step && countQ == ONE;
  assign countBusy = step;
  assign irqOut    = evtQ && maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ    <= '0;
      timeoutQ  <= TIMEOUT_RST;
      enabledQ  <= 1'b0;
      timedOutQ <= 1'b0;
      evtQ      <= 1'b0;
      maskQ     <= 1'b0;
      dbgEnQ    <= 1'b0;
      resetReq  <= 1'b0;
    end else begin
      if (stb.feed || expire) countQ <= timeoutQ;
      else if (step)          countQ <= countQ - ONE;

      if (stb.feed || stb.resume) enabledQ <= 1'b1;
      else if (stb.halt)          enabledQ <= 1'b0;

      if (stb.loadTimeout) timeoutQ <= stb.data[CNT_W-1:0];

      if (expire)               timedOutQ <= 1'b1;
      else if (stb.clearStatus) timedOutQ <= 1'b0;

      if (warn || stb.forceEvt) evtQ <= 1'b1;
      else if (stb.ackEvt)      evtQ <= 1'b0;

      if (stb.loadMask) maskQ  <= stb.data[0];
      if (stb.loadDbg)  dbgEnQ <= stb.data[0];

      resetReq <= expire;
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int CNT_W       = 15,
  parameter int DEF_TIMEOUT = 6000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  input  logic              tickEn,
  input  logic              dbgMode,
  output logic              irqOut,
  output logic              resetReq
);
  wdogStrobe_t      stb;
  logic [CNT_W-1:0] countQ, timeoutQ;
  logic             enabledQ, timedOutQ, evtQ, maskQ, dbgEnQ, countBusy;

  keyed_wdog_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .countQ(countQ), .timeoutQ(timeoutQ), .enabledQ(enabledQ),
    .timedOutQ(timedOutQ), .evtQ(evtQ), .maskQ(maskQ), .dbgEnQ(dbgEnQ),
    .dbgMode(dbgMode), .countBusy(countBusy), .stb(stb), .rdData(rdData)
  );

  keyed_wdog_dp #(.CNT_W(CNT_W), .DEF_TIMEOUT(DEF_TIMEOUT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .tickEn(tickEn), .dbgMode(dbgMode),
    .countQ(countQ), .timeoutQ(timeoutQ), .enabledQ(enabledQ),
    .timedOutQ(timedOutQ), .evtQ(evtQ), .maskQ(maskQ), .dbgEnQ(dbgEnQ),
    .countBusy(countBusy), .resetReq(resetReq), .irqOut(irqOut)
  );
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             tickEn,
  input logic             dbgMode,
  input logic             resetReq,
  input logic [CNT_W-1:0] countQ,
  input logic [CNT_W-1:0] timeoutQ,
  input logic             enabledQ,
  input logic             timedOutQ,
  input logic             dbgEnQ,
  input logic             evtQ
);
  // R5
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  // R5
  req_reloads_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> countQ == $past(timeoutQ));

  // R6
  req_sets_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> timedOutQ);

  // R7
  halted_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enabledQ && !wrEn) |=> $stable(countQ));

  // R11
  debug_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dbgMode && !dbgEnQ && !wrEn) |=> $stable(countQ));

  // R9
  warn_sets_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && enabledQ && (!dbgMode || dbgEnQ) && countQ == CNT_W'(1) && !wrEn)
      |=> evtQ);
endmodule

bind keyed_wdog keyed_wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .tickEn(tickEn), .dbgMode(dbgMode),
  .resetReq(resetReq), .countQ(countQ), .timeoutQ(timeoutQ),
  .enabledQ(enabledQ), .timedOutQ(timedOutQ), .dbgEnQ(dbgEnQ), .evtQ(evtQ)
);

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        tickEn = 1'b0;
  logic        dbgMode = 1'b0;
  logic        irqOut, resetReq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  keyed_wdog u_keyed_wdog (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .tickEn(tickEn), .dbgMode(dbgMode),
    .irqOut(irqOut), .resetReq(resetReq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic tick(output logic busy, output logic rr);
    @(negedge clk);
    tickEn = 1'b1; addr = 6'h14;
    #1;
    busy = rdData[15];
    @(negedge clk);
    tickEn = 1'b0;
    rr = resetReq;
  endtask

  initial begin
    logic [15:0] v;
    logic busy, rr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h0C, v); chk("R1 halt2", v, 16'hDABE);
    rd(6'h04, v); chk("R1 timeout", v, 16'd6000);
    rd(6'h10, v); chk("R1 status", v, 16'h0000);
    rd(6'h14, v); chk("R1 count", v, 16'h0000);
    rd(6'h20, v); chk("R1 event", v, 16'h0000);
    rd(6'h24, v); chk("R1 mask", v, 16'h0000);
    rd(6'h18, v); chk("R1 debug", v, 16'h0000);
    rd(6'h2C, v); chk("R1 undefined", v, 16'h0000);
    chk("R1 pins", {14'b0, irqOut, resetReq}, 16'h0000);

    // R3 timeout masking
    wr(6'h04, 16'hFFFF); rd(6'h04, v); chk("R3 mask15", v, 16'h7FFF);
    wr(6'h04, 16'h1234); rd(6'h04, v); chk("R3 plain", v, 16'h1234);

    // R2 wrong feed key ignored
    wr(6'h00, 16'hFEEE); rd(6'h0C, v); chk("R2 bad key", v, 16'hDABE);
    rd(6'h14, v); chk("R2 bad key count", v, 16'h0000);

    // sweep of small timeouts: R2 R4 R5 R6 R9 R10
    wr(6'h24, 16'h0001);
    for (int t = 1; t <= 5; t++) begin
      wr(6'h04, 16'(t));
      wr(6'h00, 16'hFEED);
      wr(6'h20, 16'h0001);
      rd(6'h0C, v); chk("R2 enabled", v, 16'h0000);
      rd(6'h14, v); chk("R2 load", v, 16'(t));
      for (int k = t; k >= 1; k--) begin
        tick(busy, rr);
        chk("R4 busy flag", {15'b0, busy}, 16'h0001);
        chk("R5 no early req", {15'b0, rr}, 16'h0000);
        rd(6'h14, v); chk("R4 decrement", v, 16'(k - 1));
        rd(6'h20, v); chk("R9 warn event", v, (k == 1) ? 16'h0001 : 16'h0000);
        chk("R10 irq follows", {15'b0, irqOut}, (k == 1) ? 16'h0001 : 16'h0000);
      end
      wr(6'h20, 16'h0001);
      rd(6'h20, v); chk("R9 ack", v, 16'h0000);
      tick(busy, rr);
      chk("R5 req pulse", {15'b0, rr}, 16'h0001);
      rd(6'h14, v); chk("R5 reload", v, 16'(t));
      rd(6'h10, v); chk("R6 tripped", v, 16'hCFE8);
      @(negedge clk);
      chk("R5 req drops", {15'b0, resetReq}, 16'h0000);
      rd(6'h14, v); chk("R4 stable no tick", v, 16'(t));
      wr(6'h10, 16'h1111); rd(6'h10, v); chk("R6 bad clear", v, 16'hCFE8);
      wr(6'h10, 16'hE8B4); rd(6'h10, v); chk("R6 cleared", v, 16'h0000);
    end

    // R9 R10 force, mask
    wr(6'h28, 16'h0001);
    rd(6'h20, v); chk("R9 force", v, 16'h0001);
    rd(6'h28, v); chk("R9 force reads 0", v, 16'h0000);
    chk("R10 irq on", {15'b0, irqOut}, 16'h0001);
    wr(6'h24, 16'h0000);
    chk("R10 masked", {15'b0, irqOut}, 16'h0000);
    wr(6'h20, 16'h0001);
    rd(6'h20, v); chk("R9 ack force", v, 16'h0000);

    // R7 disable sequence
    wr(6'h04, 16'd10); wr(6'h00, 16'hFEED);
    wr(6'h0C, 16'hCAFE); rd(6'h0C, v); chk("R7 unarmed", v, 16'h0000);
    wr(6'h08, 16'h2BAD); wr(6'h08, 16'h1234); wr(6'h0C, 16'hCAFE);
    rd(6'h0C, v); chk("R7 arm lost", v, 16'h0000);
    wr(6'h08, 16'h2BAD); wr(6'h0C, 16'h0000); wr(6'h0C, 16'hCAFE);
    rd(6'h0C, v); chk("R7 arm lost on halt2", v, 16'h0000);
    wr(6'h08, 16'h2BAD); wr(6'h0C, 16'hCAFE);
    rd(6'h0C, v); chk("R7 halted", v, 16'hDABE);
    tick(busy, rr);
    chk("R7 no busy", {15'b0, busy}, 16'h0000);
    rd(6'h14, v); chk("R7 held", v, 16'd10);

    // R8 resume
    wr(6'h1C, 16'hACEE); rd(6'h0C, v); chk("R8 bad key", v, 16'hDABE);
    wr(6'h1C, 16'hACED); rd(6'h0C, v); chk("R8 resumed", v, 16'h0000);
    rd(6'h14, v); chk("R8 count kept", v, 16'd10);
    tick(busy, rr);
    rd(6'h14, v); chk("R8 runs", v, 16'd9);

    // R11 debug hold and override
    @(negedge clk); dbgMode = 1'b1;
    rd(6'h18, v); chk("R11 mode bit", v, 16'h0002);
    tick(busy, rr);
    rd(6'h14, v); chk("R11 held", v, 16'd9);
    wr(6'h18, 16'h0001);
    rd(6'h18, v); chk("R11 override", v, 16'h0003);
    tick(busy, rr);
    rd(6'h14, v); chk("R11 runs", v, 16'd8);
    @(negedge clk); dbgMode = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule